// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This block is a watchdog timer that software controls through three word registers. The registers hold the timeout code, the expiry action and the control word. A prescaler divides the clock into one-second ticks. A down-counter loaded with a power-of-two number of those ticks counts toward expiry. When the count runs out, the block raises an interrupt. If the action register selects it, the block also gives a one-cycle reset pulse.

Software arms the watchdog with one control write that sets the enable and clear bits together. It keeps the watchdog alive by writing the clear bit again before expiry. After each such write it polls a read-only status bit, which reports that the reload has actually happened. Disabling the watchdog drops the status bit at once. Software waits for that before it programs a new period and re-arms.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the period register reads 3, the action register reads 0, the control register reads 0, and both `irq` and `rst_pulse` are low.
- R2: The period code is bits [3:0] at offset 0x3004. The action field is bits [1:0] at offset 0x3008. At offset 0x300C, bit 0 is enable, bit 1 is clear and always reads 0, and bit 8 is the read-only status. Written fields read back as written.
- R3: A load is either a control write with bit 0 = 1 while the watchdog is disabled, or a control write with bits 1 and 0 both set. On a load, status reads 0 for STATUS_LAG-1 cycles and then reads 1 from the STATUS_LAG-th clock edge after the write edge.
- R4: A control write with bit 0 = 0 makes status read 0 from the next cycle and freezes the countdown, so no expiry follows.
- R5: For a period code c from 3 to 10, `irq` is low through edge E+2^(c-3)*TICK_CYCLES-1 and high after edge E+2^(c-3)*TICK_CYCLES, where E is the edge of the load write.
- R6: Period codes below 3 act as 3 (one tick). Codes above 10 act as 10 (128 ticks). The register still reads back the raw code.
- R7: A period write takes effect only at the next load. It does not change a countdown that is already running.
- R8: Once raised, `irq` stays high until the next load, which drops it at the load edge.
- R9: When the countdown expires with action value 0, `rst_pulse` is high for exactly one cycle, together with `irq`. With any other action value (for example 2), `rst_pulse` stays low.
- R10: Reads from any offset other than the three registers return 0. Writes to any other offset change no register.
- R11: A clear while the watchdog runs restarts the full countdown, so expiry moves to the new load edge plus the full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Byte offset for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Expiry interrupt, held until the next load |
| rst_pulse | output | 1 | One-cycle reset request on expiry |

## Verification
The bench builds the block with TICK_CYCLES = 8 and STATUS_LAG = 4. With these values a one-second tick lasts eight clocks, so even the 128-second ceiling expires within 1024 cycles. That makes the whole code ladder, including both clamped ends, cheap to run to expiry. Because the status lag stays short and known, the bench can sample the handshake bit on the exact cycle before and after it rises.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int TICK_CYCLES = 100_000_000,
  parameter int STATUS_LAG  = 4,
  parameter int CODE_MIN    = 3,
  parameter int CODE_MAX    = 10,
  parameter int CODE_RESET  = 3,
  parameter logic [ADDR_W-1:0] OFS_PERIOD = 16'h3004,
  parameter logic [ADDR_W-1:0] OFS_ACTION = 16'h3008,
  parameter logic [ADDR_W-1:0] OFS_CTL    = 16'h300C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rst_pulse
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int SEC_W = CODE_MAX - CODE_MIN + 2;
  localparam int LAG_W = $clog2(STATUS_LAG + 1);
  localparam logic [3:0] CMIN = 4'(CODE_MIN);
  localparam logic [3:0] CMAX = 4'(CODE_MAX);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [3:0]       code_q, code_c;
  logic [1:0]       act_q;
  logic             en_q, stat_q;
  logic [PRE_W-1:0] pre_q;
  logic [SEC_W-1:0] sec_q, reload;
  logic [LAG_W-1:0] lag_q;
  logic             wr_period, wr_act, wr_ctl, en_next, load, tick;
  logic             unused_bits;

  assign wr_period = bus_wr && bus_addr == OFS_PERIOD;
  assign wr_act    = bus_wr && bus_addr == OFS_ACTION;
  assign wr_ctl    = bus_wr && bus_addr == OFS_CTL;
  assign en_next   = wr_ctl ? bus_wdata[0] : en_q;
  assign load      = wr_ctl && bus_wdata[0] && (bus_wdata[1] || !en_q);
  assign code_c    = (code_q < CMIN) ? CMIN : (code_q > CMAX) ? CMAX : code_q;
  assign reload    = SEC_W'(1) << (code_c - CMIN);
  assign tick      = en_q && pre_q == PRE_LAST;
  assign unused_bits = ^bus_wdata[DATA_W-1:4];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_PERIOD) bus_rdata[3:0] = code_q;
    if (bus_addr == OFS_ACTION) bus_rdata[1:0] = act_q;
    if (bus_addr == OFS_CTL) begin
      bus_rdata[0] = en_q;
      bus_rdata[8] = stat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= 4'(CODE_RESET);
      act_q     <= '0;
      en_q      <= 1'b0;
      stat_q    <= 1'b0;
      pre_q     <= '0;
      sec_q     <= '0;
      lag_q     <= '0;
      irq       <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (wr_period) code_q <= bus_wdata[3:0];
      if (wr_act) act_q <= bus_wdata[1:0];
      en_q <= en_next;
      if (load) begin
        pre_q  <= '0;
        sec_q  <= reload;
        lag_q  <= LAG_W'(STATUS_LAG);
        stat_q <= 1'b0;
        irq    <= 1'b0;
      end else if (!en_next) begin
        stat_q <= 1'b0;
        lag_q  <= '0;
      end else begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick && sec_q != '0) begin
          sec_q <= sec_q - 1'b1;
          if (sec_q == SEC_W'(1)) begin
            irq       <= 1'b1;
            rst_pulse <= (act_q == 2'd0);
          end
        end
        if (lag_q != '0) begin
          lag_q <= lag_q - 1'b1;
          if (lag_q == LAG_W'(1)) stat_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_PERIOD = 16'h3004,
  parameter logic [ADDR_W-1:0] OFS_ACTION = 16'h3008,
  parameter logic [ADDR_W-1:0] OFS_CTL    = 16'h300C
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              rst_pulse,
  input logic              en_q,
  input logic              stat_q,
  input logic [1:0]        act_q,
  input logic              load
);
  p_status_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !stat_q);
  p_status_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !stat_q);
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  p_pulse_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> ($past(act_q) == 2'd0 && irq));
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !load) |=> irq);
  p_clear_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTL) |-> !bus_rdata[1]);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFS_CTL && bus_addr != OFS_PERIOD && bus_addr != OFS_ACTION)
      |-> bus_rdata == '0);
endmodule

bind tick_watchdog tick_watchdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .OFS_PERIOD(OFS_PERIOD), .OFS_ACTION(OFS_ACTION), .OFS_CTL(OFS_CTL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq(irq), .rst_pulse(rst_pulse), .en_q(en_q), .stat_q(stat_q),
  .act_q(act_q), .load(load)
);

// File: tb/tb_tick_watchdog.sv
module tb_tick_watchdog;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_pulse;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int    q_at[$];
  int    q_sig[$];
  int    q_val[$];
  string q_tag[$];

  tick_watchdog #(.TICK_CYCLES(T), .STATUS_LAG(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_pulse(rst_pulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  task automatic expect_at(int at, int sig, int val, string tag);
    q_at.push_back(at); q_sig.push_back(sig);
    q_val.push_back(val); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    for (int i = q_at.size() - 1; i >= 0; i--) begin
      if (q_at[i] == cyc) begin
        chk(q_tag[i], (q_sig[i] == 0) ? int'(irq) : int'(rst_pulse), q_val[i]);
        q_at.delete(i); q_sig.delete(i); q_val.delete(i); q_tag.delete(i);
      end
    end
  end

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, output int edge_at);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    edge_at = cyc;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), int'(exp));
  endtask

  initial begin
    int e, e2, e3, e4, e5, e6, e7, e8, e9, e10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(16'h3004, 32'h3, "R1 period reset");
    rd(16'h3008, 32'h0, "R1 action reset");
    rd(16'h300C, 32'h0, "R1 ctl reset");
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 rst_pulse reset", int'(rst_pulse), 0);

    wr(16'h3004, 32'hFFFF_FFF5, e);
    rd(16'h3004, 32'h5, "R2 period readback");
    wr(16'h3008, 32'h2, e);
    rd(16'h3008, 32'h2, "R2 action readback");

    wr(16'h3010, 32'hFFFF_FFFF, e);
    wr(16'h2004, 32'h9, e);
    wr(16'h200C, 32'h3, e);
    rd(16'h3010, 32'h0, "R10 unmapped read 3010");
    rd(16'h3000, 32'h0, "R10 unmapped read 3000");
    rd(16'h3004, 32'h5, "R10 period untouched");
    rd(16'h300C, 32'h0, "R10 ctl untouched");

    // start, code 5 -> 4 ticks
    wr(16'h300C, 32'h3, e);
    expect_at(e + 4*T - 1, 0, 0, "R5 code5 irq low before");
    expect_at(e + 4*T,     0, 1, "R5 code5 irq rises");
    expect_at(e + 4*T,     1, 0, "R9 action2 no pulse");
    expect_at(e + 4*T + 8, 0, 1, "R8 irq held");
    rd(16'h300C, 32'h1, "R3 status low after load");
    wait_until(e + 3);
    rd(16'h300C, 32'h1, "R3 status low at lag-1");
    @(negedge clk);
    rd(16'h300C, 32'h101, "R3 status high at lag");
    wait_until(e + 4*T + 12);

    // clear drops irq; period change does not affect the running count
    wr(16'h300C, 32'h3, e2);
    expect_at(e2, 0, 0, "R8 clear drops irq");
    wr(16'h3004, 32'h3, e);
    expect_at(e2 + 4*T - 1, 0, 0, "R7 old period still low");
    expect_at(e2 + 4*T,     0, 1, "R7 old period expiry");
    wait_until(e2 + 4*T + 2);

    // action 0, code 3 -> one tick with reset pulse
    wr(16'h3008, 32'h0, e);
    wr(16'h300C, 32'h3, e3);
    expect_at(e3 + T - 1, 0, 0, "R5 code3 irq low before");
    expect_at(e3 + T,     0, 1, "R5 code3 irq rises");
    expect_at(e3 + T - 1, 1, 0, "R9 no pulse before expiry");
    expect_at(e3 + T,     1, 1, "R9 pulse at expiry");
    expect_at(e3 + T + 1, 1, 0, "R9 pulse one cycle");
    wait_until(e3 + T + 3);

    // ping restarts countdown, code 4 -> 2 ticks
    wr(16'h3004, 32'h4, e);
    wr(16'h300C, 32'h3, e4);
    expect_at(e4 + 2*T, 0, 0, "R11 no expiry after ping");
    wait_until(e4 + 9);
    wr(16'h300C, 32'h3, e5);
    expect_at(e5 + 2*T - 1, 0, 0, "R11 irq low before new expiry");
    expect_at(e5 + 2*T,     0, 1, "R11 expiry after ping");
    expect_at(e5 + 2*T,     1, 1, "R11 pulse after ping");
    wait_until(e5 + 2*T + 2);

    // disable freezes and drops status
    wr(16'h300C, 32'h3, e6);
    expect_at(e6 + 2*T,  0, 0, "R4 no expiry when disabled");
    expect_at(e6 + 5*T,  0, 0, "R4 still no expiry");
    wait_until(e6 + 5);
    rd(16'h300C, 32'h101, "R3 status high while running");
    wr(16'h300C, 32'h0, e7);
    rd(16'h300C, 32'h0, "R4 status drops on disable");
    wait_until(e6 + 5*T + 2);

    // clamping
    wr(16'h3004, 32'h0, e);
    rd(16'h3004, 32'h0, "R6 raw low code readback");
    wr(16'h300C, 32'h3, e8);
    expect_at(e8 + T - 1, 0, 0, "R6 low clamp before");
    expect_at(e8 + T,     0, 1, "R6 low clamp expiry");
    wait_until(e8 + T + 2);
    wr(16'h3004, 32'hF, e);
    rd(16'h3004, 32'hF, "R6 raw high code readback");
    wr(16'h300C, 32'h3, e9);
    expect_at(e9 + 128*T - 1, 0, 0, "R6 high clamp before");
    expect_at(e9 + 128*T,     0, 1, "R6 high clamp expiry");
    wait_until(e9 + 128*T + 2);

    // code 7 -> 16 ticks
    wr(16'h3004, 32'h7, e);
    wr(16'h300C, 32'h3, e10);
    expect_at(e10 + 16*T - 1, 0, 0, "R5 code7 irq low before");
    expect_at(e10 + 16*T,     0, 1, "R5 code7 irq rises");
    wait_until(e10 + 16*T + 2);

    n_chk += q_at.size();
    n_bad += q_at.size();
    if (q_at.size() != 0) $display("FAIL scoreboard: actual %0d pending expected 0", q_at.size());
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule